// File: doc/BRIEF.md
# ADC Parallel Result Read Port

This block sits between the conversion sequencer of a 16-bit sampling converter and the host data bus. It keeps the most recent conversion word and places it on a 16-line data bus when the host asserts both its active-low select and active-low read strobes. The bus is modelled as a value vector plus a per-line output enable, and the pad ring builds the tri-state buffers from those.

On its way out, the stored word passes through one output path. That path can invert the top bit, which turns offset binary into two's complement. It can also exchange the two byte lanes. Both controls act combinationally at read time, so an 8-bit host can read the low lane twice and flip the lane-exchange input between the two reads to collect the whole word. A serial-mode select releases every line of the bus, so the serial port, which is outside this block, can use the shared pins. A new word can be read in the same cycle its valid strobe is high. The stored copy changes only on that strobe.

Top module: `adc_pread_port`

## Requirements
- R1: When cs_ni or rd_ni is high, every bit of data_oe_o is 0.
- R2: When cs_ni and rd_ni are both low and serial_sel_i is low, all 16 bits of data_oe_o are 1.
- R3: With swap_i low, result bits [7:0] appear on data_o[7:0] and bits [15:8] on data_o[15:8]. With swap_i high, the two 8-bit lanes are exchanged.
- R4: With straight_bin_i high, the word passes through unchanged. With it low, bit 15 of the word is inverted before any lane exchange, which gives two's complement.
- R5: When serial_sel_i is high, data_oe_o is 0, including lines 0, 1 and 12 to 15, whatever the state of cs_ni and rd_ni.
- R6: In the cycle where result_valid_i is high, data_o already reflects result_i, so there is no pipeline delay.
- R7: The stored word is loaded only on a clock edge where result_valid_i is high. While result_valid_i and the format inputs are steady, data_o holds its value.
- R8: An 8-bit host that reads data_o[7:0] with swap_i low and then with swap_i high receives the low byte and then the high byte of the same word.
- R9: After reset, the stored word is 0x0000, so data_o reads 0x0000 in straight binary and 0x8000 in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 16 | Conversion word from the sequencer |
| result_valid_i | input | 1 | Load strobe for result_i |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| swap_i | input | 1 | Exchanges the two byte lanes when high |
| straight_bin_i | input | 1 | 1 selects straight binary, 0 selects two's complement |
| serial_sel_i | input | 1 | 1 releases the bus for serial operation |
| data_o | output | 16 | Formatted bus value |
| data_oe_o | output | 16 | Per-line drive enable |

## Verification
The hardest case to reach from the ports is showing that the stored word is untouched while result_i keeps changing with the strobe low, because the bypass path hides the register whenever the strobe is high. The bench parks a word, moves result_i to an unrelated value with the strobe held low, and reads the bus over several cycles. It then repeats the two-read byte sequence to show that both lanes come from the same stored word.

// File: rtl/adc_pread_pkg.sv
package adc_pread_pkg;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_LANE_W = 8;

  typedef struct packed {
    logic swap;
    logic straight;
  } fmt_ctrl_t;
endpackage

// File: rtl/adc_pread_hold.sv
module adc_pread_hold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] result_i,
  input  logic              valid_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= '0;
    else if (valid_i) held_q <= result_i;
  end

  // bypass: fresh result visible in its own strobe cycle
  assign word_o = valid_i ? result_i : held_q;
endmodule

// File: rtl/adc_pread_fmt.sv
module adc_pread_fmt
  import adc_pread_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic [WORD_W-1:0] word_i,
  input  fmt_ctrl_t         ctrl_i,
  output logic [WORD_W-1:0] bus_o
);
  localparam int unsigned NLANE = WORD_W / LANE_W;

  logic [WORD_W-1:0] coded;

  always_comb begin
    coded           = word_i;
    coded[WORD_W-1] = word_i[WORD_W-1] ^ ~ctrl_i.straight;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign bus_o[g*LANE_W +: LANE_W] = ctrl_i.swap ? coded[(NLANE-1-g)*LANE_W +: LANE_W]
                                                   : coded[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/adc_pread_oe.sv
module adc_pread_oe #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              serial_i,
  output logic [WORD_W-1:0] oe_o
);
  logic drive;
  assign drive = ~cs_ni & ~rd_ni & ~serial_i;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    assign oe_o[b] = drive;
  end
endmodule

// File: rtl/adc_pread_port.sv
module adc_pread_port
  import adc_pread_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] result_i,
  input  logic              result_valid_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              swap_i,
  input  logic              straight_bin_i,
  input  logic              serial_sel_i,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] data_oe_o
);
  logic [WORD_W-1:0] word;
  fmt_ctrl_t         ctrl;

  assign ctrl.swap     = swap_i;
  assign ctrl.straight = straight_bin_i;

  adc_pread_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .result_i(result_i),
    .valid_i (result_valid_i),
    .word_o  (word)
  );

  adc_pread_fmt #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_fmt (
    .word_i(word),
    .ctrl_i(ctrl),
    .bus_o (data_o)
  );

  adc_pread_oe #(.WORD_W(WORD_W)) u_oe (
    .cs_ni   (cs_ni),
    .rd_ni   (rd_ni),
    .serial_i(serial_sel_i),
    .oe_o    (data_oe_o)
  );
endmodule

// File: rtl/adc_pread_port_chk.sv
module adc_pread_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] result_i,
  input logic        result_valid_i,
  input logic        cs_ni,
  input logic        rd_ni,
  input logic        swap_i,
  input logic        straight_bin_i,
  input logic        serial_sel_i,
  input logic [15:0] data_o,
  input logic [15:0] data_oe_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_IDLE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> (data_oe_o == 16'h0)); // R1

  AST_READ_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni && !serial_sel_i) |-> (data_oe_o == 16'hFFFF)); // R2

  AST_SERIAL_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_sel_i |-> (data_oe_o[1:0] == 2'b00 && data_oe_o[15:12] == 4'h0)); // R5

  AST_BYPASS_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_i && !swap_i && straight_bin_i) |-> (data_o == result_i)); // R6

  AST_TWOS_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_i && !swap_i && !straight_bin_i) |->
      (data_o == {~result_i[15], result_i[14:0]})); // R4

  AST_SWAP_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_i && swap_i && straight_bin_i) |->
      (data_o == {result_i[7:0], result_i[15:8]})); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !result_valid_i && !$past(result_valid_i) &&
     $stable(swap_i) && $stable(straight_bin_i)) |-> $stable(data_o)); // R7
endmodule

bind adc_pread_port adc_pread_port_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .result_i      (result_i),
  .result_valid_i(result_valid_i),
  .cs_ni         (cs_ni),
  .rd_ni         (rd_ni),
  .swap_i        (swap_i),
  .straight_bin_i(straight_bin_i),
  .serial_sel_i  (serial_sel_i),
  .data_o        (data_o),
  .data_oe_o     (data_oe_o)
);

// File: tb/adc_pread_port_tb.sv
`timescale 1ns/1ps
module adc_pread_port_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] result_i = '0;
  logic        result_valid_i = 1'b0;
  logic        cs_ni = 1'b1, rd_ni = 1'b1;
  logic        swap_i = 1'b0, straight_bin_i = 1'b1, serial_sel_i = 1'b0;
  logic [15:0] data_o, data_oe_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_pread_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .result_i(result_i), .result_valid_i(result_valid_i),
    .cs_ni(cs_ni), .rd_ni(rd_ni), .swap_i(swap_i), .straight_bin_i(straight_bin_i),
    .serial_sel_i(serial_sel_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive after falling edge, settle, then sample
  task automatic settle();
    #1;
  endtask

  task automatic load(logic [15:0] w);
    @(negedge clk); result_i = w; result_valid_i = 1'b1;
    @(negedge clk); result_valid_i = 1'b0; result_i = ~w;
    settle();
  endtask

  task automatic t_reset();
    @(negedge clk); straight_bin_i = 1'b1; cs_ni = 0; rd_ni = 0; settle();
    check("R9 reset straight", data_o, 16'h0000);
    straight_bin_i = 1'b0; settle();
    check("R9 reset twos", data_o, 16'h8000);
    straight_bin_i = 1'b1; cs_ni = 1; rd_ni = 1;
  endtask

  task automatic t_enable();
    load(16'h1234);
    @(negedge clk); cs_ni = 1; rd_ni = 1; settle();
    check("R1 both high", data_oe_o, 16'h0000);
    cs_ni = 0; settle();
    check("R1 rd high", data_oe_o, 16'h0000);
    cs_ni = 1; rd_ni = 0; settle();
    check("R1 cs high", data_oe_o, 16'h0000);
    cs_ni = 0; settle();
    check("R2 read drives", data_oe_o, 16'hFFFF);
    check("R2 read value", data_o, 16'h1234);
  endtask

  task automatic t_swap_fmt();
    load(16'hA55C);
    @(negedge clk); swap_i = 0; straight_bin_i = 1; settle();
    check("R3 no swap", data_o, 16'hA55C);
    swap_i = 1; settle();
    check("R3 swapped", data_o, 16'h5CA5);
    swap_i = 0; straight_bin_i = 0; settle();
    check("R4 twos", data_o, 16'h255C);
    swap_i = 1; settle();
    check("R4 twos swapped", data_o, 16'h5C25);
    swap_i = 0; straight_bin_i = 1;
  endtask

  task automatic t_serial();
    @(negedge clk); serial_sel_i = 1; cs_ni = 0; rd_ni = 0; settle();
    check("R5 serial release", data_oe_o, 16'h0000);
    check("R5 serial lines 0,1,12-15", {data_oe_o[15:12], 10'd0, data_oe_o[1:0]}, 16'h0000);
    serial_sel_i = 0; settle();
    check("R5 back to parallel", data_oe_o, 16'hFFFF);
  endtask

  task automatic t_bypass();
    @(negedge clk); result_i = 16'h7E01; result_valid_i = 1'b1; settle();
    check("R6 same cycle", data_o, 16'h7E01);
    @(negedge clk); result_valid_i = 1'b0; result_i = 16'h0000; settle();
    check("R6 after strobe", data_o, 16'h7E01);
  endtask

  task automatic t_hold();
    load(16'h3C96);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); result_i = 16'hF00F ^ 16'(i); settle();
      check("R7 held without strobe", data_o, 16'h3C96);
    end
  endtask

  task automatic t_byte_read();
    logic [7:0] lo, hi;
    load(16'hBEEF);
    @(negedge clk); swap_i = 0; settle(); lo = data_o[7:0];
    @(negedge clk); result_i = 16'h1111; swap_i = 1; settle(); hi = data_o[7:0];
    check("R8 byte pair", {hi, lo}, 16'hBEEF);
    straight_bin_i = 0; swap_i = 1; settle();
    check("R8 high byte twos", {8'h00, data_o[7:0]}, 16'h003E);
    swap_i = 0; straight_bin_i = 1;
  endtask

  initial begin
    #12 rst_ni = 1'b1;
    t_reset();
    t_enable();
    t_swap_fmt();
    t_serial();
    t_bypass();
    t_hold();
    t_byte_read();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule